// File: doc/BRIEF.md
# Exception Entry and Vector Selector

This block is the sequencing step a processor core runs when an exception is raised. On a one-cycle raise strobe it takes the exception code, the coprocessor number, the faulting program counter, a delay-slot flag, the relevant status bits and the faulting address with the last address-translation outcome. One cycle later it presents everything the control registers and the fetch unit need: the new exception PC and branch-delay flag, the cause fields, an EXL-set strobe, and the fetch redirect target with its strobe.

Translation misses have a fast refill path. Whether it is used depends on whether the core was already handling an exception, on whether the translation failed outright or found an invalid entry, and on the 64-bit addressing enable of the segment the faulting address belongs to. A separate combinational path turns a translation outcome and an access direction into the exception code the core should raise. Register storage and the translator are outside this block.

Top module: `exc_vector_unit`

## Requirements
- R1: On a raise with `exl_i` low, `epc_we_o` pulses and `epc_o` carries `pc_i`, with `bd_o` low when `delay_slot_i` is low; with `exl_i` high, `epc_we_o` stays low.
- R2: On a raise with `exl_i` low and `delay_slot_i` high, `epc_o` is `pc_i` minus 4 and `bd_o` is high.
- R3: Every raise gives `exl_set_o` high for one cycle, with `cause_code_o` equal to `code_i` and `cause_cop_o` equal to `cop_i`.
- R4: General codes (0 interrupt, 1 modification, 4/5 address error, 6/7 bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 unusable coprocessor, 12 overflow, 13 trap, 15 floating point, 23 watch) redirect to 0xFFFFFFFF80000180.
- R5: Codes 2 (translation load) and 3 (translation store) redirect to 0xFFFFFFFF80000180 when `exl_i` was high or `xlat_err_i` is 2 (invalid).
- R6: Otherwise codes 2 and 3 redirect to 0xFFFFFFFF80000080 when the segment of `bad_addr_i` has 64-bit addressing, else to 0xFFFFFFFF80000000; address bits 63:62 choose the enable: 00 `ux_i`, 01 `sx_i`, 11 `kx_i`, 10 never.
- R7: With `bev_i` high a raise gives `unsupported_o` and no redirect.
- R8: A code outside the R4–R6 lists gives `unsupported_o` and no redirect.
- R9: `redirect_o` or `unsupported_o` (never both) is high exactly in the cycle after each raise and low otherwise, including after reset.
- R10: Translation outcome mapping (`xlat_err_i` 0 none, 1 miss, 2 invalid, 3 modification, 4 disallowed): miss or invalid give 2 for loads and 3 for stores, modification gives 1, disallowed gives 4 for loads and 5 for stores; none or other values drop `map_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | Exception raise strobe |
| code_i | input | 5 | Exception code |
| cop_i | input | 2 | Coprocessor number for the cause |
| pc_i | input | 64 | Faulting program counter |
| delay_slot_i | input | 1 | Faulting instruction sits in a delay slot |
| exl_i | input | 1 | Exception level before this raise |
| bev_i | input | 1 | Bootstrap vector select |
| ux_i | input | 1 | 64-bit addressing, user segment |
| sx_i | input | 1 | 64-bit addressing, supervisor segment |
| kx_i | input | 1 | 64-bit addressing, kernel segment |
| bad_addr_i | input | 64 | Faulting virtual address |
| xlat_err_i | input | 3 | Last translation outcome |
| xlat_store_i | input | 1 | Access was a store |
| redirect_o | output | 1 | Fetch redirect strobe |
| vector_o | output | 64 | Redirect target |
| unsupported_o | output | 1 | Unsupported condition strobe |
| exl_set_o | output | 1 | Set EXL strobe |
| epc_we_o | output | 1 | EPC and delay flag write strobe |
| epc_o | output | 64 | New EPC value |
| bd_o | output | 1 | New branch-delay flag |
| cause_code_o | output | 5 | Cause exception code |
| cause_cop_o | output | 2 | Cause coprocessor number |
| map_valid_o | output | 1 | Mapped code is meaningful |
| map_code_o | output | 5 | Exception code for the translation outcome |

## Verification
The hardest case is the fast refill target, which needs EXL clear, a miss rather than an invalid entry, and a faulting address whose top two bits select an enable that is set; the stimulus walks all four segment values with each enable toggled alone, including the 10 segment with every enable high. Delay-slot entries with EXL already set are mixed in so the EPC hold is seen against a changing PC, and raises are issued back to back to show each result leaves in its own cycle.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int XLEN   = 64,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        cop_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              delay_slot_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              ux_i,
  input  logic              sx_i,
  input  logic              kx_i,
  input  logic [XLEN-1:0]   bad_addr_i,
  input  logic [2:0]        xlat_err_i,
  input  logic              xlat_store_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   vector_o,
  output logic              unsupported_o,
  output logic              exl_set_o,
  output logic              epc_we_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              bd_o,
  output logic [CODE_W-1:0] cause_code_o,
  output logic [1:0]        cause_cop_o,
  output logic              map_valid_o,
  output logic [CODE_W-1:0] map_code_o
);
  localparam int HI = XLEN - 32;
  localparam logic [XLEN-1:0] V_GEN  = {{HI{1'b1}}, 32'h8000_0180};
  localparam logic [XLEN-1:0] V_WIDE = {{HI{1'b1}}, 32'h8000_0080};
  localparam logic [XLEN-1:0] V_NARR = {{HI{1'b1}}, 32'h8000_0000};
  localparam logic [2:0] E_MISS = 3'd1, E_INV = 3'd2, E_MOD = 3'd3, E_DIS = 3'd4;

  logic is_general, is_xlat, wide, fast, ok;
  logic [XLEN-1:0] vec_n;

  always_comb begin
    case (code_i)
      5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
      5'd10, 5'd11, 5'd12, 5'd13, 5'd15, 5'd23: is_general = 1'b1;
      default: is_general = 1'b0;
    endcase
  end

  assign is_xlat = (code_i == 5'd2) || (code_i == 5'd3);

  always_comb begin
    case (bad_addr_i[XLEN-1 -: 2])
      2'b00:   wide = ux_i;
      2'b01:   wide = sx_i;
      2'b11:   wide = kx_i;
      default: wide = 1'b0;
    endcase
  end

  assign fast  = is_xlat && !exl_i && (xlat_err_i != E_INV);
  assign vec_n = fast ? (wide ? V_WIDE : V_NARR) : V_GEN;
  assign ok    = (is_general || is_xlat) && !bev_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      unsupported_o <= 1'b0;
      exl_set_o     <= 1'b0;
      epc_we_o      <= 1'b0;
      vector_o      <= '0;
      epc_o         <= '0;
      bd_o          <= 1'b0;
      cause_code_o  <= '0;
      cause_cop_o   <= '0;
    end else begin
      redirect_o    <= raise_i && ok;
      unsupported_o <= raise_i && !ok;
      exl_set_o     <= raise_i;
      epc_we_o      <= raise_i && !exl_i;
      if (raise_i) begin
        vector_o     <= vec_n;
        cause_code_o <= code_i;
        cause_cop_o  <= cop_i;
        if (!exl_i) begin
          epc_o <= delay_slot_i ? pc_i - XLEN'(4) : pc_i;
          bd_o  <= delay_slot_i;
        end
      end
    end
  end

  always_comb begin
    map_valid_o = 1'b1;
    case (xlat_err_i)
      E_MISS, E_INV: map_code_o = xlat_store_i ? CODE_W'(3) : CODE_W'(2);
      E_MOD:         map_code_o = CODE_W'(1);
      E_DIS:         map_code_o = xlat_store_i ? CODE_W'(5) : CODE_W'(4);
      default: begin
        map_code_o  = '0;
        map_valid_o = 1'b0;
      end
    endcase
  end

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect_o, unsupported_o}));
  a_r9_follows_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o || unsupported_o) |-> $past(raise_i));
  a_r3_exl_each_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $past(raise_i) |-> exl_set_o && (redirect_o || unsupported_o));
  a_r1_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we_o |-> !$past(exl_i));
  a_r7_bev_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> !$past(bev_i));
  a_r2_delay_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (epc_we_o && bd_o) |-> epc_o == $past(pc_i) - XLEN'(4));
  always_comb begin
    a_r10_map_range: assert (!map_valid_o || (map_code_o >= CODE_W'(1) && map_code_o <= CODE_W'(5)));
  end
endmodule

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic raise = 0, dly = 0, exl = 0, bev = 0, ux = 0, sx = 0, kx = 0, st = 0;
  logic [4:0] code = 0;
  logic [1:0] cop = 0;
  logic [63:0] pc = 0, bad = 0;
  logic [2:0] xerr = 0;
  logic redirect, unsup, exl_set, epc_we, bd, map_valid;
  logic [63:0] vector, epc;
  logic [4:0] ccode, map_code;
  logic [1:0] ccop;

  always #2 clk = ~clk;

  exc_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .raise_i(raise), .code_i(code), .cop_i(cop), .pc_i(pc),
    .delay_slot_i(dly), .exl_i(exl), .bev_i(bev), .ux_i(ux), .sx_i(sx), .kx_i(kx),
    .bad_addr_i(bad), .xlat_err_i(xerr), .xlat_store_i(st),
    .redirect_o(redirect), .vector_o(vector), .unsupported_o(unsup), .exl_set_o(exl_set),
    .epc_we_o(epc_we), .epc_o(epc), .bd_o(bd), .cause_code_o(ccode), .cause_cop_o(ccop),
    .map_valid_o(map_valid), .map_code_o(map_code));

  typedef struct packed {
    logic        uns;
    logic [63:0] vec;
    logic        we;
    logic [63:0] epc;
    logic        bd;
    logic [4:0]  code;
    logic [1:0]  cop;
    logic [7:0]  req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [63:0] VG = 64'hFFFF_FFFF_8000_0180;
  localparam logic [63:0] VW = 64'hFFFF_FFFF_8000_0080;
  localparam logic [63:0] VN = 64'hFFFF_FFFF_8000_0000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic fire(input logic [4:0] c, input logic [1:0] cp, input logic [63:0] p, input logic d,
                      input logic e, input logic b, input logic [2:0] u3, input logic [63:0] ba,
                      input logic [2:0] er, input logic [7:0] rq);
    exp_t x;
    bit gen, tl, w;
    gen = c inside {0, 1, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 15, 23};
    tl  = (c == 2) || (c == 3);
    case (ba[63:62]) 2'b00: w = u3[2]; 2'b01: w = u3[1]; 2'b11: w = u3[0]; default: w = 0; endcase
    x.uns = b || !(gen || tl);
    x.vec = (tl && !e && er != 3'd2) ? (w ? VW : VN) : VG;
    x.we = !e; x.epc = d ? p - 64'd4 : p; x.bd = d;
    x.code = c; x.cop = cp; x.req = rq;
    q.push_back(x);
    code = c; cop = cp; pc = p; dly = d; exl = e; bev = b;
    {ux, sx, kx} = u3; bad = ba; xerr = er; raise = 1;
    @(negedge clk);
    raise = 0;
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (exl_set) begin
      exp_t x;
      string r;
      if (q.size() == 0) chk(0, "R9 unexpected result", 64'd1, 64'd0);
      else begin
        x = q.pop_front();
        r = $sformatf("R%0d", x.req);
        chk(unsup == x.uns && redirect == !x.uns, {r, "/R7/R8/R9 strobes"}, {unsup, redirect}, {x.uns, !x.uns});
        if (!x.uns) chk(vector == x.vec, {r, " vector R4/R5/R6"}, vector, x.vec);
        chk(epc_we == x.we, "R1 epc write", epc_we, x.we);
        if (x.we) chk(epc == x.epc && bd == x.bd, "R2 epc/bd", {epc[62:0], bd}, {x.epc[62:0], x.bd});
        chk(ccode == x.code && ccop == x.cop, "R3 cause", {ccop, ccode}, {x.cop, x.code});
      end
    end else if (redirect || unsup)
      chk(0, "R9 strobe without raise", {unsup, redirect}, 64'd0);
  end

  task automatic map(input logic [2:0] er, input logic s, input logic v, input logic [4:0] c);
    xerr = er; st = s; #1;
    chk(map_valid == v && (!v || map_code == c), "R10 mapping", {map_valid, map_code}, {v, c});
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!redirect && !unsup && !exl_set && !epc_we, "R9 reset state", {redirect, unsup, exl_set, epc_we}, 0);
    rst_n = 1;
    @(negedge clk);
    fire(8, 0, 64'h0000_0000_0040_1000, 0, 0, 0, 3'b000, 0, 0, 4);
    @(negedge clk);
    fire(11, 1, 64'hFFFF_FFFF_8000_1234, 1, 0, 0, 3'b000, 0, 0, 2);
    @(negedge clk);
    fire(0, 0, 64'h1111, 1, 1, 0, 3'b000, 0, 0, 1);
    @(negedge clk);
    fire(2, 0, 64'h2000, 0, 0, 0, 3'b100, 64'h0000_0000_0000_4000, 1, 6);
    fire(2, 0, 64'h2004, 0, 0, 0, 3'b011, 64'h0000_0000_0000_4000, 1, 6);
    fire(3, 0, 64'h2008, 0, 0, 0, 3'b010, 64'h4000_0000_0000_0000, 1, 6);
    fire(3, 0, 64'h200C, 0, 0, 0, 3'b101, 64'h4000_0000_0000_0000, 1, 6);
    fire(2, 0, 64'h2010, 0, 0, 0, 3'b001, 64'hC000_0000_0000_0000, 1, 6);
    fire(2, 0, 64'h2014, 0, 0, 0, 3'b111, 64'h8000_0000_0000_0000, 1, 6);
    @(negedge clk);
    fire(3, 0, 64'h3000, 0, 0, 0, 3'b111, 0, 2, 5);
    fire(2, 0, 64'h3004, 1, 1, 0, 3'b111, 0, 1, 5);
    fire(1, 0, 64'h3008, 0, 0, 0, 3'b000, 0, 3, 4);
    fire(23, 2, 64'h300C, 0, 0, 0, 3'b000, 0, 0, 4);
    @(negedge clk);
    fire(8, 0, 64'h4000, 0, 0, 1, 3'b000, 0, 0, 7);
    fire(14, 0, 64'h4004, 0, 0, 0, 3'b000, 0, 0, 8);
    fire(31, 3, 64'h4008, 1, 0, 0, 3'b000, 0, 0, 8);
    @(negedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R9 all results seen", q.size(), 0);
    map(0, 0, 0, 0); map(1, 0, 1, 2); map(1, 1, 1, 3); map(2, 0, 1, 2);
    map(2, 1, 1, 3); map(3, 0, 1, 1); map(3, 1, 1, 1); map(4, 0, 1, 4);
    map(4, 1, 1, 5); map(7, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule